// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block ends the low-power standby state of a small 8-bit processor. The core sends a one-cycle request to enter standby. The block then drops its clock-run output and watches the wake sources: a non-maskable interrupt, a set of external maskable interrupt lines and a bus request. Reset is also a wake cause. Each source is checked against its own enable. The global interrupt enable plays no part in this check. When a source qualifies, the block records it as the wake cause. It then counts a fixed oscillator settling window before it raises clock-run again.

When the clocks resume, the block tells the core what to do next. A non-maskable wake gives a one-cycle start pulse for the non-maskable acknowledge. A maskable wake gives a one-cycle forward pulse on that line, but only when both the global flag and the line's enable are set. Interrupt line 0 is a special case. It must stay asserted for the whole settling window. If it drops early and another qualified source is pending, the block adopts that source as the cause and keeps counting. If no other source is pending, the block returns to standby with the counter cleared. After any exit, the bus stays released for as long as the bus request remains asserted.

All pins are plain control and status levels or pulses. There is no streaming data path and no back-pressure. The oscillator, the acknowledge cycles and the core itself are outside the block.

Top module: `stby_wake_ctrl`

## Requirements
- R1: During reset, clk_run is 1, wake_cause is 6'b000001 (bit 0 = reset cause), bus_released is 1, and nmi_ack and int_fwd are 0.
- R2: An enter_stby pulse while clk_run is 1 makes clk_run 0 and wake_cause all-zero from the next cycle onward.
- R3: In standby, an asserted busreq ends standby only while brx_en is 1. In that case wake_cause bit 5 is set.
- R4: In standby, nmi_in always ends standby and sets wake_cause bit 1. nmi_ack is high for exactly the first cycle in which clk_run is 1 again.
- R5: In standby, int_in[i] ends standby only when int_en[i] is 1, whatever the value of gie. The cause bit is 2+i.
- R6: clk_run rises exactly 2^STAB_BITS clock edges after the edge that accepts the wake source.
- R7: If line 0 is the cause and int_in[0] is low at any edge of the settling window, including the last one, and no other qualified source is present, the block returns to standby. wake_cause becomes 0 and the count restarts from zero on the next wake.
- R8: If line 0 is the cause and int_in[0] drops while another qualified source is present, wake_cause switches to that source. clk_run still rises at the original time.
- R9: When several sources qualify in the same cycle, the cause follows this priority: NMI (bit 1), then line 0, line 1, line 2 (bits 2 to 4), then the bus request (bit 5). wake_cause is never more than one-hot.
- R10: On resume after a maskable wake through line i, int_fwd[i] pulses for one cycle only if gie and int_en[i] are both 1. Otherwise int_fwd stays 0.
- R11: bus_released follows busreq after each exit. It goes to 0 one edge after busreq is sampled low and stays 0 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_stby | input | 1 | One-cycle request from the core to enter standby |
| nmi_in | input | 1 | Non-maskable interrupt request |
| int_in | input | NUM_INT | External maskable interrupt lines |
| int_en | input | NUM_INT | Per-line enables from the interrupt control register |
| gie | input | 1 | Global interrupt enable flag of the core |
| brx_en | input | 1 | Allows a bus request to end standby |
| busreq | input | 1 | External bus request |
| clk_run | output | 1 | High while internal and output clocks may run |
| wake_cause | output | NUM_INT+3 | One-hot cause of the last exit, 0 while waiting in standby |
| nmi_ack | output | 1 | One-cycle start of the non-maskable acknowledge |
| int_fwd | output | NUM_INT | One-cycle forward of a maskable wake to the core |
| bus_released | output | 1 | Bus held released to the external requester |

## Verification
If the settling counter were wrong, clk_run would rise on the wrong edge. This shows up at the first wake, one window after the wake source is accepted. If the qualification or priority logic were wrong, wake_cause would hold an unexpected bit on the cycle right after acceptance. A line-0 cancel that failed would show as clk_run rising even though the line was released. A cancel that did not clear the counter would show as clk_run rising early on the next wake. Errors in the forwarding gate appear as int_fwd or nmi_ack values on the single resume cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_STAB = 2'd2
  } stby_state_e;

  // positions inside the one-hot cause vector
  localparam int IDX_RST  = 0;
  localparam int IDX_NMI  = 1;
  localparam int IDX_INT0 = 2;
endpackage

// File: rtl/stby_src_qual.sv
module stby_src_qual
  import stby_pkg::*;
#(
  parameter int NUM_INT = 3,
  localparam int CAUSE_W = NUM_INT + 3
) (
  input  logic               nmi_in,
  input  logic [NUM_INT-1:0] int_in,
  input  logic [NUM_INT-1:0] int_en,
  input  logic               busreq,
  input  logic               brx_en,
  input  logic               mask_int0,
  output logic [CAUSE_W-1:0] sel,
  output logic               any
);
  logic [CAUSE_W-1:0] req;

  always_comb begin
    req = '0;
    req[IDX_NMI] = nmi_in;
    for (int i = 0; i < NUM_INT; i++) begin
      req[IDX_INT0+i] = int_in[i] & int_en[i] & ~((i == 0) & mask_int0);
    end
    req[CAUSE_W-1] = busreq & brx_en;
  end

  // lowest index wins: NMI, then lines in order, then bus request
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 1; i < CAUSE_W; i++) begin
      if (req[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt #(
  parameter int WIDTH = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = &cnt_q;
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int STAB_BITS = 17,
  parameter int NUM_INT   = 3,
  localparam int CAUSE_W  = NUM_INT + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter_stby,
  input  logic               nmi_in,
  input  logic [NUM_INT-1:0] int_in,
  input  logic [NUM_INT-1:0] int_en,
  input  logic               gie,
  input  logic               brx_en,
  input  logic               busreq,
  output logic               clk_run,
  output logic [CAUSE_W-1:0] wake_cause,
  output logic               nmi_ack,
  output logic [NUM_INT-1:0] int_fwd,
  output logic               bus_released
);
  stby_state_e        state_q;
  logic [CAUSE_W-1:0] cause_q, sel_all, sel_alt, cause_nx;
  logic [NUM_INT-1:0] fwd_nx;
  logic               any_all, any_alt, cnt_done, cnt_clr, cnt_en;
  logic               int0_lost, cancel, rel_q;

  stby_src_qual #(.NUM_INT(NUM_INT)) u_qual_all (
    .nmi_in(nmi_in), .int_in(int_in), .int_en(int_en), .busreq(busreq),
    .brx_en(brx_en), .mask_int0(1'b0), .sel(sel_all), .any(any_all)
  );

  // same qualification with line 0 removed: the fallback when it drops
  stby_src_qual #(.NUM_INT(NUM_INT)) u_qual_alt (
    .nmi_in(nmi_in), .int_in(int_in), .int_en(int_en), .busreq(busreq),
    .brx_en(brx_en), .mask_int0(1'b1), .sel(sel_alt), .any(any_alt)
  );

  assign int0_lost = (state_q == ST_STAB) && cause_q[IDX_INT0] && !int_in[0];
  assign cancel    = int0_lost && !any_alt;
  assign cause_nx  = int0_lost ? sel_alt : cause_q;
  assign cnt_clr   = (state_q != ST_STAB) || cancel;
  assign cnt_en    = (state_q == ST_STAB);

  stby_stab_cnt #(.WIDTH(STAB_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .done(cnt_done)
  );

  for (genvar g = 0; g < NUM_INT; g++) begin : g_fwd
    assign fwd_nx[g] = cause_nx[IDX_INT0+g] & gie & int_en[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cause_q <= CAUSE_W'(1) << IDX_RST;
      nmi_ack <= 1'b0;
      int_fwd <= '0;
    end else begin
      nmi_ack <= 1'b0;
      int_fwd <= '0;
      unique case (state_q)
        ST_RUN: if (enter_stby) begin
          state_q <= ST_STBY;
          cause_q <= '0;
        end
        ST_STBY: if (any_all) begin
          state_q <= ST_STAB;
          cause_q <= sel_all;
        end
        ST_STAB: begin
          if (cancel) begin
            state_q <= ST_STBY;
            cause_q <= '0;
          end else begin
            cause_q <= cause_nx;
            if (cnt_done) begin
              state_q <= ST_RUN;
              nmi_ack <= cause_nx[IDX_NMI];
              int_fwd <= fwd_nx;
            end
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // bus stays released after an exit for as long as the request holds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rel_q <= 1'b1;
    else if (state_q == ST_RUN)  rel_q <= rel_q & busreq;
    else                         rel_q <= busreq;
  end

  assign clk_run      = (state_q == ST_RUN);
  assign wake_cause   = cause_q;
  assign bus_released = rel_q;
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk #(
  parameter int NUM_INT = 3,
  localparam int CAUSE_W = NUM_INT + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enter_stby,
  input logic               nmi_in,
  input logic [NUM_INT-1:0] int_in,
  input logic [NUM_INT-1:0] int_en,
  input logic               gie,
  input logic               brx_en,
  input logic               busreq,
  input logic               clk_run,
  input logic [CAUSE_W-1:0] wake_cause,
  input logic               nmi_ack,
  input logic [NUM_INT-1:0] int_fwd,
  input logic               bus_released
);
  logic other_src, any_src, only_int0;

  always_comb begin
    other_src = nmi_in | (busreq & brx_en);
    for (int i = 1; i < NUM_INT; i++) other_src = other_src | (int_in[i] & int_en[i]);
    any_src   = other_src | (int_in[0] & int_en[0]);
  end
  assign only_int0 = (wake_cause == CAUSE_W'(4));

  AST_ENTER_STOPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run && enter_stby |=> !clk_run && (wake_cause == '0)); // R2
  AST_NO_SRC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run && (wake_cause == '0) && !any_src |=> !clk_run && (wake_cause == '0)); // R3
  AST_NMI_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> clk_run && wake_cause[1] ##1 !nmi_ack); // R4
  AST_RESUME_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_run) |-> $past(wake_cause) != '0); // R6
  AST_INT0_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run && only_int0 && !int_in[0] && !other_src |=> !clk_run && (wake_cause == '0)); // R7
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause)); // R9
  AST_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fwd != '0) |-> $past(gie) && clk_run && $onehot(int_fwd)); // R10
  AST_REL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !busreq |=> !bus_released); // R11
endmodule

bind stby_wake_ctrl stby_wake_chk #(.NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .enter_stby(enter_stby), .nmi_in(nmi_in),
  .int_in(int_in), .int_en(int_en), .gie(gie), .brx_en(brx_en),
  .busreq(busreq), .clk_run(clk_run), .wake_cause(wake_cause),
  .nmi_ack(nmi_ack), .int_fwd(int_fwd), .bus_released(bus_released)
);

// File: tb/stby_wake_ctrl_bench.sv
module stby_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SB   = 3;
  localparam int STAB = 1 << SB;

  logic clk = 1'b0, rst_n = 1'b0, enter_stby = 1'b0, nmi_in = 1'b0;
  logic [2:0] int_in = '0, int_en = '0, int_fwd;
  logic gie = 1'b0, brx_en = 1'b0, busreq = 1'b0;
  logic clk_run, nmi_ack, bus_released;
  logic [5:0] wake_cause;
  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_wake_ctrl #(.STAB_BITS(SB), .NUM_INT(3)) u_stby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .enter_stby(enter_stby), .nmi_in(nmi_in),
    .int_in(int_in), .int_en(int_en), .gie(gie), .brx_en(brx_en),
    .busreq(busreq), .clk_run(clk_run), .wake_cause(wake_cause),
    .nmi_ack(nmi_ack), .int_fwd(int_fwd), .bus_released(bus_released)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter();
    enter_stby = 1'b1;
    tick(1);
    enter_stby = 1'b0;
    check("R2 clk_run", 32'(clk_run), 0);
    check("R2 cause", 32'(wake_cause), 0);
  endtask

  task automatic clear_src();
    nmi_in = 1'b0; int_in = '0; busreq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(2);
    check("R1 clk_run", 32'(clk_run), 1);
    check("R1 cause", 32'(wake_cause), 32'h01);
    check("R1 bus_released", 32'(bus_released), 1);
    check("R1 pulses", {28'd0, nmi_ack, int_fwd}, 0);
    rst_n = 1'b1;
    tick(1);
    check("R11 release after reset", 32'(bus_released), 0);
    check("R1 clk_run", 32'(clk_run), 1);

    // sweep of every source/enable/gie combination
    for (int c = 0; c < 1024; c++) begin
      logic [5:0] req, exp_cause;
      logic [2:0] exp_fwd;
      logic exp_brq;
      int_en = c[6:4]; brx_en = c[8]; gie = c[9];
      enter();
      nmi_in = c[0]; int_in = c[3:1]; busreq = c[7];
      tick(1);
      req = {busreq & brx_en, int_in & int_en, nmi_in, 1'b0};
      exp_cause = '0;
      for (int b = 5; b >= 1; b--) if (req[b]) exp_cause = 6'(1) << b;
      if (exp_cause == '0) begin
        tick(2);
        check(busreq ? "R3 masked busreq" : "R5 disabled line", 32'(clk_run), 0);
        check("R5 cause empty", 32'(wake_cause), 0);
        clear_src();
        nmi_in = 1'b1;
        exp_cause = 6'h02;
        tick(1);
      end
      exp_brq = busreq;
      check("R9 cause", 32'(wake_cause), 32'(exp_cause));
      exp_fwd = gie ? exp_cause[4:2] : 3'b000;
      tick(STAB - 1);
      check("R6 still stopped", 32'(clk_run), 0);
      tick(1);
      check("R6 resumed", 32'(clk_run), 1);
      check("R4 nmi_ack", 32'(nmi_ack), 32'(exp_cause[1]));
      check("R10 int_fwd", 32'(int_fwd), 32'(exp_fwd));
      check("R11 held", 32'(bus_released), 32'(exp_brq));
      tick(1);
      check("R10 pulse width", {28'd0, nmi_ack, int_fwd}, 0);
      clear_src();
      tick(1);
      check("R11 dropped", 32'(bus_released), 0);
    end

    // R7: line 0 released mid-window, then restart from zero
    int_en = 3'b001; brx_en = 1'b1; gie = 1'b1;
    enter();
    int_in = 3'b001;
    tick(1);
    check("R7 cause", 32'(wake_cause), 32'h04);
    tick(3);
    int_in = 3'b000;
    tick(1);
    check("R7 back to standby", 32'(clk_run), 0);
    check("R7 cause cleared", 32'(wake_cause), 0);
    tick(2);
    check("R7 stays", 32'(clk_run), 0);
    int_in = 3'b001;
    tick(STAB);
    check("R7 counter restarted", 32'(clk_run), 0);
    tick(1);
    check("R7 resumed", 32'(clk_run), 1);
    check("R10 fwd line0", 32'(int_fwd), 1);
    clear_src(); tick(1);

    // R7: release on the final edge of the window
    enter();
    int_in = 3'b001;
    tick(STAB);
    int_in = 3'b000;
    tick(1);
    check("R7 last edge cancel", 32'(clk_run), 0);
    check("R7 last edge cause", 32'(wake_cause), 0);
    nmi_in = 1'b1;
    tick(STAB + 1);
    check("R4 nmi resume", 32'(clk_run), 1);
    clear_src(); tick(1);

    // R8: line 0 drops with line 1 pending
    int_en = 3'b011; gie = 1'b0;
    enter();
    int_in = 3'b011;
    tick(1);
    check("R8 initial cause", 32'(wake_cause), 32'h04);
    tick(3);
    int_in = 3'b010;
    tick(1);
    check("R8 switched cause", 32'(wake_cause), 32'h08);
    tick(STAB - 5);
    check("R8 still stopped", 32'(clk_run), 0);
    tick(1);
    check("R8 original time", 32'(clk_run), 1);
    check("R10 gie low", 32'(int_fwd), 0);
    clear_src(); tick(1);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule